// File: doc/BRIEF.md
# Grouped Priority Rule Scheduler

This block arbitrates among a fixed set of guarded actions ("rules") in a synchronous design. Each rule raises a ready flag when its guard holds and offers a candidate value for each shared register. The block decides, combinationally and again in every cycle, which rules fire. It then loads the shared registers from the winners on the next rising clock edge.

Rules are sorted into conflict groups by an elaboration-time group number per rule. Each group has its own priority encoder, and within a group the lowest-numbered ready rule wins. Rules in different groups never contend, so several rules can fire in one cycle, one per group. Which registers each rule writes is also fixed by a parameter bit mask. Every register gets an AND-OR selector and a load enable built from the grants of its writers.

The configuration must place all writers of any one register in the same group. When it does, a register never has two granted writers in one cycle.

Top module: `rule_sched_top`

## Requirements
- R1: A rule's `fire_o` bit is high only while its `ready_i` bit is high.
- R2: Among the rules that share a group number, no more than one `fire_o` bit is high in any cycle.
- R3: When at least one rule of a group is ready, exactly one rule of that group fires.
- R4: Within a group, the ready rule with the smallest index is the one that fires.
- R5: Rules with different group numbers are scheduled independently. With the default configuration, rules 2 (group 0), 4 (group 1) and 7 (group 2) all fire together when all three are ready.
- R6: A register written by a firing rule takes that rule's value for it at the next rising clock edge. The value for rule r and register k sits at `value_i[(r*NUM_REGS+k)*DATA_W +: DATA_W]`. Rule r writes register k when bit `r*NUM_REGS+k` of `RULE_WRMASK` is set.
- R7: A register whose writers are all idle keeps its value across the clock edge.
- R8: A firing rule's value for a register it does not write has no effect on that register.
- R9: A synchronous, active-high `rst_i` clears every register to zero at the next rising edge, whatever the ready inputs are.
- R10: `fire_o` follows `ready_i` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; registers update on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ready_i | input | NUM_RULES | Per-rule guard (ready predicate) |
| value_i | input | NUM_RULES*NUM_REGS*DATA_W | Candidate value of each rule for each register |
| fire_o | output | NUM_RULES | Per-rule grant, combinational |
| regs_o | output | NUM_REGS*DATA_W | Contents of the shared registers, register k at bits k*DATA_W |

## Verification
The hardest situation to reach is a single cycle in which every group has several ready members at once. Only then do the priority choices of all groups and the independence between groups show up together, and only then is a register's selector offered values from writers that lost. Directed tasks build such ready patterns by hand, with a different value in every rule/register field so that a wrong pick is visible. A long run of random ready vectors and values then checks every group for one-hot-or-zero grants and the ready-implies-fire relations. The same run compares the registers against a model kept in the bench.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Bit offset of the field of rule `rule_idx` for register `reg_idx`
  // inside the flattened candidate-value bus.
  function automatic int unsigned fld_lo(input int unsigned rule_idx,
                                         input int unsigned reg_idx,
                                         input int unsigned n_regs,
                                         input int unsigned data_w);
    return (rule_idx * n_regs + reg_idx) * data_w;
  endfunction

endpackage

// File: rtl/grp_prio_arb.sv
// One conflict group: lowest-index request wins.
module grp_prio_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  // isolate the lowest set bit
  assign gnt_o = req_i & ~(req_i - N'(1));

  // R1
  gnt_subset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (gnt_o & ~req_i) == '0);

  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(gnt_o));

  // R3
  gnt_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i != '0) |-> ($countones(gnt_o) == 1));

endmodule

// File: rtl/reg_update_mux.sv
// One shared register: AND-OR select of writer values, OR of writer grants.
module reg_update_mux #(
  parameter int                   NUM_RULES = 8,
  parameter int                   DATA_W    = 8,
  parameter logic [NUM_RULES-1:0] WRITERS   = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [NUM_RULES-1:0]          fire_i,
  input  logic [NUM_RULES*DATA_W-1:0]   cand_i,
  output logic [DATA_W-1:0]             q_o
);

  logic              load_en;
  logic [DATA_W-1:0] next_val;

  always_comb begin
    load_en  = 1'b0;
    next_val = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (WRITERS[r]) begin
        load_en  = load_en | fire_i[r];
        next_val = next_val | (cand_i[r*DATA_W +: DATA_W] & {DATA_W{fire_i[r]}});
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        q_o <= '0;
    else if (load_en) q_o <= next_val;
  end

  // R6
  load_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_en |=> (q_o == $past(next_val)));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_en |=> $stable(q_o));

endmodule

// File: rtl/rule_sched_top.sv
module rule_sched_top #(
  parameter int NUM_RULES  = 8,
  parameter int NUM_REGS   = 4,
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 3,
  parameter int GID_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  // group number of rule r at bits [r*GID_W +: GID_W]
  parameter logic [NUM_RULES*GID_W-1:0]    RULE_GROUP  = 16'hA940,
  // rule r writes register k when bit r*NUM_REGS+k is set
  parameter logic [NUM_RULES*NUM_REGS-1:0] RULE_WRMASK = 32'h8804_4231
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic [NUM_RULES-1:0]                ready_i,
  input  logic [NUM_RULES*NUM_REGS*DATA_W-1:0] value_i,
  output logic [NUM_RULES-1:0]                fire_o,
  output logic [NUM_REGS*DATA_W-1:0]          regs_o
);
  import sched_pkg::*;

  localparam int CAND_W = NUM_RULES * DATA_W;

  function automatic logic [NUM_RULES-1:0] writers_of(input int k);
    logic [NUM_RULES-1:0] m;
    for (int r = 0; r < NUM_RULES; r++) m[r] = RULE_WRMASK[r*NUM_REGS + k];
    return m;
  endfunction

  logic [NUM_RULES-1:0] grp_member [NUM_GROUPS];
  logic [NUM_RULES-1:0] grp_gnt    [NUM_GROUPS];

  // one priority encoder per conflict group
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_mem
      assign grp_member[g][r] = (RULE_GROUP[r*GID_W +: GID_W] == GID_W'(g));
    end
    grp_prio_arb #(.N(NUM_RULES)) arb_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .req_i (ready_i & grp_member[g]),
      .gnt_o (grp_gnt[g])
    );
  end

  always_comb begin
    fire_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) fire_o = fire_o | grp_gnt[g];
  end

  // per-register update selector
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [CAND_W-1:0] cand;
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_cand
      assign cand[r*DATA_W +: DATA_W] = value_i[fld_lo(r, k, NUM_REGS, DATA_W) +: DATA_W];
    end
    reg_update_mux #(
      .NUM_RULES (NUM_RULES),
      .DATA_W    (DATA_W),
      .WRITERS   (writers_of(k))
    ) mux_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fire_i (fire_o),
      .cand_i (cand),
      .q_o    (regs_o[k*DATA_W +: DATA_W])
    );
  end

  // R1
  fire_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_o & ~ready_i) == '0);

  // R9
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (regs_o == '0));

endmodule

// File: tb/rule_sched_top_tb.sv
module rule_sched_top_tb_top;
  import sched_pkg::*;

  localparam int NR = 8, NK = 4, DW = 8, NGRP = 3, GW = 2;
  localparam logic [NR*GW-1:0] GIDS = 16'hA940;      // 0,0,0,1,1,2,2,2
  localparam logic [NR*NK-1:0] WM   = 32'h8804_4231;

  logic               clk = 1'b0;
  logic               rst;
  logic [NR-1:0]      rdy;
  logic [NR*NK*DW-1:0] val;
  logic [NR-1:0]      fire;
  logic [NK*DW-1:0]   regs;
  logic [DW-1:0]      mdl [NK];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rule_sched_top #(
    .NUM_RULES(NR), .NUM_REGS(NK), .DATA_W(DW), .NUM_GROUPS(NGRP), .GID_W(GW),
    .RULE_GROUP(GIDS), .RULE_WRMASK(WM)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .ready_i(rdy), .value_i(val),
    .fire_o(fire), .regs_o(regs)
  );

  function automatic logic [NR-1:0] exp_fire(input logic [NR-1:0] r);
    logic [NR-1:0] f = '0;
    for (int i = 0; i < NR; i++) begin
      bit blocked = 1'b0;
      for (int j = 0; j < i; j++)
        if (r[j] && GIDS[j*GW +: GW] == GIDS[i*GW +: GW]) blocked = 1'b1;
      f[i] = r[i] && !blocked;
    end
    return f;
  endfunction

  function automatic logic [NR*NK*DW-1:0] mkval(input logic [DW-1:0] seed);
    logic [NR*NK*DW-1:0] v;
    for (int i = 0; i < NR; i++)
      for (int k = 0; k < NK; k++)
        v[fld_lo(i, k, NK, DW) +: DW] = DW'((i << 4) | k) ^ seed;
    return v;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_regs(input string rq);
    for (int k = 0; k < NK; k++)
      chk(regs[k*DW +: DW] == mdl[k], rq, 64'(regs[k*DW +: DW]), 64'(mdl[k]));
  endtask

  // drive one cycle, check grants before the edge, registers after it
  task automatic apply(input logic [NR-1:0] r, input logic [NR*NK*DW-1:0] v,
                       input string rq);
    logic [NR-1:0] ef;
    @(negedge clk);
    rdy = r; val = v;
    #1;
    ef = exp_fire(r);
    chk(fire == ef, rq, 64'(fire), 64'(ef));
    for (int k = 0; k < NK; k++)
      for (int i = 0; i < NR; i++)
        if (ef[i] && WM[i*NK + k]) mdl[k] = v[fld_lo(i, k, NK, DW) +: DW];
    @(posedge clk); #1;
    check_regs(rq);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; rdy = '1; val = mkval(8'h5A);
    @(posedge clk); @(posedge clk); #1;
    for (int k = 0; k < NK; k++) mdl[k] = '0;
    check_regs("R9");
    @(negedge clk); rst = 1'b0; rdy = '0;
  endtask

  task automatic t_single;
    for (int i = 0; i < NR; i++) apply(NR'(1) << i, mkval(8'(i * 17)), "R6");
  endtask

  task automatic t_priority;
    apply(8'hFF, mkval(8'h11), "R4");
    apply(8'b0000_0110, mkval(8'h22), "R4");
    apply(8'b1100_0000, mkval(8'h33), "R4");
    apply(8'b0001_1000, mkval(8'h44), "R4");
  endtask

  task automatic t_groups;
    apply(8'b1001_0100, mkval(8'h66), "R5");
    chk(fire == 8'b1001_0100, "R5", 64'(fire), 64'h94);
  endtask

  task automatic t_hold;
    apply(8'h00, mkval(8'h77), "R7");
    apply(8'b0010_0000, mkval(8'h88), "R7");
  endtask

  task automatic t_ignore;
    // rule 0 writes only register 0; its other fields must not land
    apply(8'b0000_0001, mkval(8'h99), "R8");
    apply(8'b0000_1000, mkval(8'hAB), "R8");
  endtask

  task automatic t_comb;
    @(negedge clk);
    rdy = 8'b0000_0100; val = mkval(8'h0F);
    #1;
    chk(fire == 8'b0000_0100, "R10", 64'(fire), 64'h04);
    rdy = 8'b0100_0011;
    #1;
    chk(fire == 8'b0100_0001, "R10", 64'(fire), 64'h41);
    for (int k = 0; k < NK; k++)
      for (int i = 0; i < NR; i++)
        if (exp_fire(rdy)[i] && WM[i*NK + k]) mdl[k] = val[fld_lo(i, k, NK, DW) +: DW];
    @(posedge clk); #1;
    check_regs("R10");
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [NR*NK*DW-1:0] v;
      logic [NR-1:0] r;
      for (int w = 0; w < NR*NK*DW/32; w++) v[w*32 +: 32] = $urandom;
      r = NR'($urandom);
      apply(r, v, "R6");
      @(negedge clk); #0;
      rdy = r;
      #1;
      chk((fire & ~r) == '0, "R1", 64'(fire), 64'(fire & r));
      for (int g = 0; g < NGRP; g++) begin
        int cnt = 0; bit any = 1'b0;
        for (int i = 0; i < NR; i++)
          if (GIDS[i*GW +: GW] == GW'(g)) begin
            cnt += int'(fire[i]);
            any |= r[i];
          end
        chk(cnt <= 1, "R2", 64'(cnt), 64'd1);
        chk(!any || cnt == 1, "R3", 64'(cnt), 64'd1);
      end
      rdy = '0;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; rdy = '0; val = '0;
    for (int k = 0; k < NK; k++) mdl[k] = '0;
    t_reset;
    t_single;
    t_priority;
    t_groups;
    t_hold;
    t_ignore;
    t_comb;
    t_random;
    t_reset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule